// File: doc/BRIEF.md
# Threshold-Filtered Event Counter

This block accumulates a per-cycle event count (0 to 15 occurrences per clock) into a 40-bit counter. In raw mode the counter grows by the full per-cycle count. In compare mode each cycle is judged against a 4-bit threshold, and the counter grows by exactly one when the test passes. The complement bit turns the test from "greater than" into "less than or equal". An edge option limits counting to the first cycle of a run of passing cycles.

The counter wraps silently past all-ones and sets a sticky overflow flag. It can also raise a one-cycle interrupt pulse. Software uses it in one of two ways. It can let the count run and read it back. Or it can preload a negative value so that the counter overflows after a chosen number of counts. A force-overflow bit makes every non-zero increment act as an overflow. Software clears the flag by rewriting the control word.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the counter is 0, every control bit is 0 and the interrupt output is low.
- R2: Asserting `cnt_wr` loads all 40 bits of `cnt_wdata` into the counter at the next edge. In that cycle the load takes precedence over counting.
- R3: With enable (control bit 0) set and compare (bit 1) clear, each cycle adds the raw value of `evt_cnt` to the counter.
- R4: With compare set and complement (bit 2) clear, the counter grows by exactly one in a cycle whose `evt_cnt` exceeds the threshold (bits 6:3), and by zero otherwise.
- R5: With compare and complement set, the counter grows by one in a cycle whose `evt_cnt` is less than or equal to the threshold. A threshold of 15 therefore counts every cycle.
- R6: With compare and edge (bit 7) set, the counter grows by one only in a cycle where the threshold test passes and failed in the previous cycle.
- R7: With enable clear, `evt_cnt` has no effect and the counter holds its value.
- R8: A counter that passes all-ones wraps modulo 2^40, keeps counting and sets the sticky overflow flag (bit 10). A preload of -N therefore overflows on the Nth unit count.
- R9: `irq` pulses high for one cycle after an overflow, and only when interrupt-enable (bit 9) is set.
- R10: With force-overflow (bit 8) set, any cycle that adds a non-zero amount sets the overflow flag. A cycle that adds zero does not.
- R11: A control write replaces the whole control word, so writing bit 10 as 0 clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cnt | input | 4 | Events seen this cycle |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 11 | Control word to write |
| cnt_wr | input | 1 | Counter preload strobe |
| cnt_wdata | input | 40 | Counter preload value |
| ctl_rdata | output | 11 | Current control word including the overflow flag |
| cnt_q | output | 40 | Current counter value |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hardest state to reach from the ports is a real 40-bit carry. Counting up from zero would take an impossible number of cycles. The stimulus therefore preloads a value a few counts below the wrap point and then feeds unit or multi-unit event counts across it. It checks the counter, the sticky flag and the single-cycle interrupt on each side of the carry. Edge mode is prepared with idle cycles after the control write, so that the previous-cycle test result is known to be false before the first pulse.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
    localparam int THR_W = 4;

    typedef struct packed {
        logic             ovf;
        logic             irq_en;
        logic             force_ovf;
        logic             edge_md;
        logic [THR_W-1:0] thr;
        logic             cmpl;
        logic             cmp;
        logic             en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/evt_thresh_filter.sv
module evt_thresh_filter #(
    parameter int EVT_W = 4
) (
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] thr,
    input  logic             cmp,
    input  logic             cmpl,
    input  logic             edge_md,
    input  logic             prev_pass,
    output logic             pass,
    output logic             hit
);
    logic above;

    always_comb begin
        above = (evt > thr);
        if (cmp) begin
            pass = cmpl ? !above : above;
        end else begin
            pass = (evt != '0);
        end
        hit = edge_md ? (pass && !prev_pass) : pass;
    end
endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
    parameter int CNT_W = 40,
    parameter int ADD_W = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [ADD_W-1:0] add,
    output logic [CNT_W-1:0] sum,
    output logic             carry
);
    localparam int WIDE = CNT_W + 1;
    logic [WIDE-1:0] wide;

    generate
        if (ADD_W < WIDE) begin : g_ext
            assign wide = {1'b0, cnt} + {{(WIDE-ADD_W){1'b0}}, add};
        end else begin : g_trunc
            assign wide = {1'b0, cnt} + add[WIDE-1:0];
        end
    endgenerate

    assign sum   = wide[CNT_W-1:0];
    assign carry = wide[CNT_W];
endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] evt_cnt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             irq;
    } state_t;

    state_t s_q, s_d;

    logic             pass;
    logic             hit;
    logic [THR_W-1:0] add_amt;
    logic [CNT_W-1:0] sum;
    logic             carry;
    logic             ovf_evt;

    evt_thresh_filter #(.EVT_W(THR_W)) u_filt (
        .evt       (evt_cnt),
        .thr       (s_q.ctl.thr),
        .cmp       (s_q.ctl.cmp),
        .cmpl      (s_q.ctl.cmpl),
        .edge_md   (s_q.ctl.edge_md),
        .prev_pass (s_q.prev),
        .pass      (pass),
        .hit       (hit)
    );

    always_comb begin
        add_amt = '0;
        if (s_q.ctl.en) begin
            if (!s_q.ctl.cmp) begin
                add_amt = evt_cnt;
            end else if (hit) begin
                add_amt = THR_W'(1);
            end
        end
    end

    evt_accum #(.CNT_W(CNT_W), .ADD_W(THR_W)) u_acc (
        .cnt   (s_q.cnt),
        .add   (add_amt),
        .sum   (sum),
        .carry (carry)
    );

    always_comb begin
        s_d      = s_q;
        ovf_evt  = !cnt_wr && (carry || (s_q.ctl.force_ovf && add_amt != '0));
        s_d.prev = pass;
        s_d.cnt  = cnt_wr ? cnt_wdata : sum;
        if (ctl_wr) begin
            s_d.ctl = ctl_t'(ctl_wdata);
        end
        if (ovf_evt) begin
            s_d.ctl.ovf = 1'b1;
        end
        s_d.irq = ovf_evt && s_q.ctl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_rdata = s_q.ctl;
    assign cnt_q     = s_q.cnt;
    assign irq       = s_q.irq;
endmodule

// File: rtl/evt_thresh_counter_chk.sv
module evt_thresh_counter_chk
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [THR_W-1:0] evt_cnt,
    input logic             ctl_wr,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             irq
);
    ctl_t c;
    assign c = ctl_t'(ctl_rdata);

    a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(cnt_wdata));

    a_r3_raw_add: assert property (@(posedge clk) disable iff (!rst_n)
        (c.en && !c.cmp && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'($past(evt_cnt)));

    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c.en && c.cmp && !cnt_wr) |=> (cnt_q - $past(cnt_q)) <= CNT_W'(1));

    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!c.en && !cnt_wr) |=> $stable(cnt_q));

    a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(c.irq_en));

    a_r8_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> c.ovf);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !c.en) |=> !irq);
endmodule

bind evt_thresh_counter evt_thresh_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_cnt   (evt_cnt),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .ctl_rdata (ctl_rdata),
    .cnt_q     (cnt_q),
    .irq       (irq)
);

// File: tb/tb_evt_thresh_counter.sv
`timescale 1ns/1ps
module tb_evt_thresh_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_cnt = '0;
    logic        ctl_wr = 1'b0;
    logic [10:0] ctl_wdata = '0;
    logic        cnt_wr = 1'b0;
    logic [39:0] cnt_wdata = '0;
    logic [10:0] ctl_rdata;
    logic [39:0] cnt_q;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    evt_thresh_counter dut (
        .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .ctl_rdata(ctl_rdata), .cnt_q(cnt_q), .irq(irq)
    );

    // control word: {ovf, field, vector expectation} entries: ctl(11) evt(4) delta(4)
    localparam int NV = 13;
    localparam logic [18:0] VEC [NV] = '{
        {11'h001, 4'd5,  4'd5},   // R3 raw
        {11'h001, 4'd15, 4'd15},  // R3 raw max
        {11'h001, 4'd0,  4'd0},   // R3 raw zero
        {11'h033, 4'd7,  4'd1},   // R4 thr 6, above
        {11'h033, 4'd6,  4'd0},   // R4 thr 6, equal
        {11'h037, 4'd6,  4'd1},   // R5 thr 6, equal
        {11'h037, 4'd7,  4'd0},   // R5 thr 6, above
        {11'h07F, 4'd15, 4'd1},   // R5 thr 15 always
        {11'h07F, 4'd0,  4'd1},   // R5 thr 15 always
        {11'h003, 4'd0,  4'd0},   // R4 thr 0, zero
        {11'h003, 4'd1,  4'd1},   // R4 thr 0, one
        {11'h000, 4'd9,  4'd0},   // R7 disabled raw
        {11'h036, 4'd9,  4'd0}    // R7 disabled compare
    };

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_both(input logic [10:0] c, input logic [39:0] v);
        ctl_wr = 1'b1; ctl_wdata = c; cnt_wr = 1'b1; cnt_wdata = v; evt_cnt = '0;
        tick();
        ctl_wr = 1'b0; cnt_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1 cnt", cnt_q, 40'd0);
        check("R1 ctl", {29'd0, ctl_rdata}, 40'd0);
        check("R1 irq", {39'd0, irq}, 40'd0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            wr_both(VEC[i][18:8], 40'd0);
            evt_cnt = VEC[i][7:4];
            tick();
            evt_cnt = '0;
            check($sformatf("R3-7 vector %0d", i), cnt_q, {36'd0, VEC[i][3:0]});
        end

        // R2: preload wins over counting in same cycle
        ctl_wr = 1'b1; ctl_wdata = 11'h001; tick(); ctl_wr = 1'b0;
        cnt_wr = 1'b1; cnt_wdata = 40'hA5_1234_5678; evt_cnt = 4'd7;
        tick();
        cnt_wr = 1'b0; evt_cnt = '0;
        check("R2 preload", cnt_q, 40'hA5_1234_5678);

        // R6 edge mode, threshold 2
        wr_both(11'h093, 40'd0);
        tick(); tick();
        evt_cnt = 4'd5; tick();
        check("R6 first pass", cnt_q, 40'd1);
        evt_cnt = 4'd5; tick();
        check("R6 held pass", cnt_q, 40'd1);
        evt_cnt = 4'd0; tick();
        check("R6 fail", cnt_q, 40'd1);
        evt_cnt = 4'd4; tick();
        evt_cnt = 4'd0;
        check("R6 second edge", cnt_q, 40'd2);

        // R8/R9 wrap with irq enabled, preload -3
        wr_both(11'h201, 40'hFF_FFFF_FFFD);
        evt_cnt = 4'd1; tick();
        check("R8 pre wrap", cnt_q, 40'hFF_FFFF_FFFE);
        check("R9 no irq yet", {39'd0, irq}, 40'd0);
        tick();
        check("R8 all ones", cnt_q, 40'hFF_FFFF_FFFF);
        check("R8 no flag yet", {39'd0, ctl_rdata[10]}, 40'd0);
        tick();
        evt_cnt = 4'd0;
        check("R8 wrapped", cnt_q, 40'd0);
        check("R8 flag set", {39'd0, ctl_rdata[10]}, 40'd1);
        check("R9 irq pulse", {39'd0, irq}, 40'd1);
        tick();
        check("R9 pulse ends", {39'd0, irq}, 40'd0);
        check("R8 sticky", {39'd0, ctl_rdata[10]}, 40'd1);
        evt_cnt = 4'd2; tick(); evt_cnt = 4'd0;
        check("R8 keeps counting", cnt_q, 40'd2);
        // R11 clear flag via control write
        ctl_wr = 1'b1; ctl_wdata = 11'h201; tick(); ctl_wr = 1'b0;
        check("R11 flag cleared", {39'd0, ctl_rdata[10]}, 40'd0);

        // R8 multi-unit carry without irq enable: R9 negative
        wr_both(11'h001, 40'hFF_FFFF_FFFD);
        evt_cnt = 4'd5; tick(); evt_cnt = 4'd0;
        check("R8 carry by 5", cnt_q, 40'd2);
        check("R8 flag by 5", {39'd0, ctl_rdata[10]}, 40'd1);
        check("R9 no irq when disabled", {39'd0, irq}, 40'd0);

        // R10 force overflow
        wr_both(11'h101, 40'd0);
        tick();
        check("R10 zero add no flag", {39'd0, ctl_rdata[10]}, 40'd0);
        evt_cnt = 4'd2; tick(); evt_cnt = 4'd0;
        check("R10 count", cnt_q, 40'd2);
        check("R10 forced flag", {39'd0, ctl_rdata[10]}, 40'd1);

        finish_run();
    end
endmodule